// File: doc/BRIEF.md
# Configuration Request Packet Generator

This block turns a single configuration-space read or write request into a fixed four-dword packet. The packet goes out on a 32-bit streaming transmit port with valid/ready flow control. The request names a target bus, device, function and register offset, gives an access size of byte, halfword or dword, and carries the write data when it is a write. From these the block chooses between local (Type 0) and forwarded (Type 1) encoding. It also fills in three header dwords, works out the byte enables and moves the write data into the byte lanes selected by the offset.

The request and the transmit port both use valid/ready. A request is taken only while the block is idle. All request fields, and the secondary and root bus numbers, are captured when the request is accepted. From then on the four words leave in a fixed order, and each word is held until the sink accepts it. Once the last word is taken the block is idle again.

Top module: `cfg_pkt_gen`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `tx_valid` and `busy` are 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `busy` is 1, `req_ready` is 0 and `tx_valid` is 1. This lasts until the cycle after the fourth word is accepted, when `busy` and `tx_valid` return to 0 and `req_ready` to 1.
- R3: Each packet is exactly four words. `tx_sop` is set only on the first word and `tx_eop` only on the fourth. A word advances only on an edge where `tx_valid` and `tx_ready` are both 1, and `tx_data`, `tx_sop` and `tx_eop` stay unchanged while `tx_ready` is 0.
- R4: Word 0 bits 31:24 carry the format/type code: 0x04 for a local read, 0x44 for a local write, 0x05 for a forwarded read and 0x45 for a forwarded write.
- R5: Forwarded encoding is used exactly when `req_bus` is strictly greater than `sec_bus` as captured at acceptance. When the two are equal, or `req_bus` is lower, local encoding is used.
- R6: Word 0 bits 9:0 hold the length 1, and bits 23:10 are 0.
- R7: Word 1 holds `root_bus` (as captured) in bits 31:24, zero in bits 23:16, and the tag in bits 15:8. The tag is 0x1D for reads and 0x10 for writes.
- R8: Word 2 holds the bus in bits 31:24, the device in bits 23:19 and the function in bits 18:16. Bits 15:12 are zero, and bits 11:0 hold `req_offset` with its two low bits cleared.
- R9: Word 1 bits 7:0 are the byte enables, which depend on `req_size` (0 = byte, 1 = halfword, 2 or 3 = dword). For a byte access they are 0x01 shifted left by `req_offset[1:0]`. For a halfword access they are 0x03 shifted left by `req_offset[1:0]`, kept to 8 bits. For a dword access they are 0x0F.
- R10: For a write, word 3 is the write data masked to the access size and shifted left by 8 × `req_offset[1:0]`, kept to 32 bits. A dword access is not shifted. For a read, word 3 is 0.
- R11: While `busy` is 1, changes on `req_valid`, on the request fields, on `sec_bus` and on `root_bus` have no effect on the packet in flight, and no second packet starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_offset | input | 12 | Register byte offset |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, right-justified |
| sec_bus | input | 8 | Secondary bus number used for the encoding choice |
| root_bus | input | 8 | Bus number placed in the requester ID |
| tx_valid | output | 1 | Transmit word valid |
| tx_ready | input | 1 | Sink accepts the word |
| tx_data | output | 32 | Transmit word |
| tx_sop | output | 1 | First word of the packet |
| tx_eop | output | 1 | Last word of the packet |
| busy | output | 1 | Packet in flight |

## Verification
Requests are sent with the target bus below, equal to and above the secondary bus number, so that the strict comparison between local and forwarded encoding is tested at its boundary. Byte accesses at each of the four lane offsets and halfword accesses at offsets 2 and 3 separate the enable shift from the data shift, and show the bits that drop off the top. A dword write at an unaligned offset shows that the offset is cleared in word 2 while the data stays unshifted, and a read carrying non-zero write data must still send a zero data word. A stalled sink combined with a request held during the stall, and with changed bus numbers, shows that words are held and that the request inputs are ignored while a packet is in flight.

// File: rtl/cfgpkt_pkg.sv
package cfgpkt_pkg;
  localparam int BUS_W     = 8;
  localparam int DEV_W     = 5;
  localparam int FN_W      = 3;
  localparam int OFF_W     = 12;
  localparam int DW_W      = 32;
  localparam int BE_W      = 8;
  localparam int LEN_W     = 10;
  localparam int PKT_WORDS = 4;
  localparam int LANES     = DW_W / 8;
  localparam int LANE_SEL_W = $clog2(LANES);

  localparam logic [7:0]       TAG_RD  = 8'h1D;
  localparam logic [7:0]       TAG_WR  = 8'h10;
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_WRD2 = 2'd3
  } acc_size_e;

  typedef logic [DW_W-1:0] dword_t;
endpackage

// File: rtl/cfgpkt_lane_align.sv
module cfgpkt_lane_align
  import cfgpkt_pkg::*;
(
  input  logic                  is_write,
  input  logic [1:0]            size,
  input  logic [LANE_SEL_W-1:0] lane,
  input  dword_t                wdata,
  output logic [BE_W-1:0]       byte_en,
  output dword_t                lane_data
);
  logic [BE_W-1:0] base_be;
  dword_t          masked;
  logic            whole;

  always_comb begin
    whole = 1'b0;
    case (acc_size_e'(size))
      ACC_BYTE: begin
        base_be = BE_W'(8'h01);
        masked  = {{(DW_W-8){1'b0}}, wdata[7:0]};
      end
      ACC_HALF: begin
        base_be = BE_W'(8'h03);
        masked  = {{(DW_W-16){1'b0}}, wdata[15:0]};
      end
      default: begin
        base_be = BE_W'({LANES{1'b1}});
        masked  = wdata;
        whole   = 1'b1;
      end
    endcase

    if (whole) begin
      byte_en   = base_be;
      lane_data = masked;
    end else begin
      byte_en   = base_be << lane;
      lane_data = masked << {lane, 3'b000};
    end

    if (!is_write) lane_data = '0;
  end
endmodule

// File: rtl/cfgpkt_hdr_build.sv
module cfgpkt_hdr_build
  import cfgpkt_pkg::*;
(
  input  logic                    is_write,
  input  logic [BUS_W-1:0]        bus,
  input  logic [DEV_W-1:0]        dev,
  input  logic [FN_W-1:0]         fn,
  input  logic [OFF_W-3:0]        off_dw,
  input  logic [BUS_W-1:0]        sec_bus,
  input  logic [BUS_W-1:0]        root_bus,
  input  logic [BE_W-1:0]         byte_en,
  input  dword_t                  lane_data,
  output dword_t [PKT_WORDS-1:0]  words
);
  localparam int GAP0_W = DW_W - 8 - LEN_W;
  localparam int GAP2_W = DW_W - BUS_W - DEV_W - FN_W - OFF_W;

  logic       fwd;
  logic [7:0] fmt_type;
  logic [7:0] tag;

  always_comb begin
    fwd      = bus > sec_bus;
    fmt_type = {1'b0, is_write, 3'b000, 1'b1, 1'b0, fwd};
    tag      = is_write ? TAG_WR : TAG_RD;

    words[0] = {fmt_type, {GAP0_W{1'b0}}, LEN_ONE};
    words[1] = {root_bus, 8'h00, tag, byte_en};
    words[2] = {bus, dev, fn, {GAP2_W{1'b0}}, off_dw, 2'b00};
    words[3] = lane_data;
  end
endmodule

// File: rtl/cfgpkt_tx_seq.sv
module cfgpkt_tx_seq
  import cfgpkt_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  dword_t [PKT_WORDS-1:0] words,
  input  logic                   tx_ready,
  output logic                   busy,
  output dword_t                 tx_data,
  output logic                   tx_sop,
  output logic                   tx_eop
);
  localparam int CNT_W = $clog2(PKT_WORDS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_WORDS - 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PKT_WORDS - 2);

  dword_t [PKT_WORDS-1:0] hold_q;
  logic   [CNT_W-1:0]     cnt_q;
  logic                   busy_q, sop_q, eop_q;
  logic                   fire;

  assign fire = busy_q & tx_ready;

  always_ff @(posedge clk) begin
    if (load) begin
      hold_q <= words;
    end else if (fire) begin
      for (int i = 0; i < PKT_WORDS - 1; i++) hold_q[i] <= hold_q[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sop_q  <= 1'b0;
      eop_q  <= 1'b0;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      sop_q  <= 1'b1;
      eop_q  <= 1'b0;
    end else if (fire) begin
      sop_q <= 1'b0;
      if (cnt_q == LAST_IDX) begin
        busy_q <= 1'b0;
        eop_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        eop_q <= (cnt_q == PRE_LAST);
      end
    end
  end

  assign busy    = busy_q;
  assign tx_data = hold_q[0];
  assign tx_sop  = sop_q;
  assign tx_eop  = eop_q;
endmodule

// File: rtl/cfg_pkt_gen.sv
module cfg_pkt_gen
  import cfgpkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FN_W-1:0]   req_fn,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [1:0]        req_size,
  input  logic [DW_W-1:0]   req_wdata,
  input  logic [BUS_W-1:0]  sec_bus,
  input  logic [BUS_W-1:0]  root_bus,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DW_W-1:0]   tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              busy
);
  logic [BE_W-1:0]        byte_en;
  dword_t                 lane_data;
  dword_t [PKT_WORDS-1:0] words;
  logic                   busy_w;
  logic                   load;

  assign load      = req_valid & ~busy_w;
  assign req_ready = ~busy_w;
  assign busy      = busy_w;
  assign tx_valid  = busy_w;

  cfgpkt_lane_align u_lane (
    .is_write  (req_write),
    .size      (req_size),
    .lane      (req_offset[LANE_SEL_W-1:0]),
    .wdata     (req_wdata),
    .byte_en   (byte_en),
    .lane_data (lane_data)
  );

  cfgpkt_hdr_build u_hdr (
    .is_write  (req_write),
    .bus       (req_bus),
    .dev       (req_dev),
    .fn        (req_fn),
    .off_dw    (req_offset[OFF_W-1:2]),
    .sec_bus   (sec_bus),
    .root_bus  (root_bus),
    .byte_en   (byte_en),
    .lane_data (lane_data),
    .words     (words)
  );

  cfgpkt_tx_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .words    (words),
    .tx_ready (tx_ready),
    .busy     (busy_w),
    .tx_data  (tx_data),
    .tx_sop   (tx_sop),
    .tx_eop   (tx_eop)
  );
endmodule

// File: rtl/cfg_pkt_gen_chk.sv
module cfg_pkt_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_data,
  input logic        tx_sop,
  input logic        tx_eop,
  input logic        busy
);
  a_r2_accept_starts: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (tx_valid && tx_sop && busy && !req_ready));

  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

  a_r3_eop_releases: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_eop) |=> (!tx_valid && !busy && req_ready));

  a_r3_no_restart: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !tx_eop) |=> (tx_valid && !tx_sop));

  a_r3_flags_apart: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $onehot0({tx_sop, tx_eop}));

  a_r4_fmt_code: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_sop) |->
      (tx_data[31:24] inside {8'h04, 8'h44, 8'h05, 8'h45}));

  a_r6_length: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_sop) |-> (tx_data[9:0] == 10'd1 && tx_data[23:10] == 14'd0));

  a_r11_ready_idle: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);
endmodule

bind cfg_pkt_gen cfg_pkt_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .tx_sop    (tx_sop),
  .tx_eop    (tx_eop),
  .busy      (busy)
);

// File: tb/cfg_pkt_gen_tb.sv
`timescale 1ns/1ps
module cfg_pkt_gen_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_write;
  logic [7:0]  req_bus;
  logic [4:0]  req_dev;
  logic [2:0]  req_fn;
  logic [11:0] req_offset;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic [7:0]  sec_bus, root_bus;
  logic        tx_valid, tx_ready, tx_sop, tx_eop, busy;
  logic [31:0] tx_data;

  always #4 clk = ~clk;

  cfg_pkt_gen u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .sec_bus(sec_bus), .root_bus(root_bus), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int ready_mode = 0;
  bit run_model = 0;
  bit finished  = 0;
  logic [33:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_word(input int idx);
    int lo, fmt, be, tag;
    longint mask, d;
    lo  = int'(req_offset) % 4;
    fmt = 4 + (req_write ? 64 : 0) + ((int'(req_bus) > int'(sec_bus)) ? 1 : 0);
    tag = req_write ? 16 : 29;
    case (int'(req_size))
      0: begin be = 1 << lo;         mask = 64'hFF; end
      1: begin be = (3 << lo) % 256; mask = 64'hFFFF; end
      default: begin be = 15;        mask = 64'hFFFF_FFFF; lo = 0; end
    endcase
    d = req_write ? (((longint'(req_wdata) & mask) << (8 * lo)) & 64'hFFFF_FFFF) : 0;
    case (idx)
      0: return 32'(longint'(fmt) * 64'd16777216 + 1);
      1: return 32'(longint'(root_bus) * 64'd16777216 + tag * 256 + be);
      2: return 32'(longint'(req_bus) * 64'd16777216 + longint'(req_dev) * 524288
                    + longint'(req_fn) * 65536 + (int'(req_offset) / 4) * 4);
      default: return 32'(d);
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Reference model: compares outputs, then predicts the state after the next edge.
  always @(negedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=<50000 cycles", cyc);
      finish_run();
    end
    if (run_model) begin
      int idx;
      bit pending;
      pending = exp_q.size() != 0;
      chk(tx_valid == pending, "R2 tx_valid", tx_valid, pending);
      chk(busy == pending, "R2 busy", busy, pending);
      chk(req_ready == !pending, "R2/R11 req_ready", req_ready, !pending);
      if (tx_valid && pending) begin
        idx = 4 - exp_q.size();
        chk(tx_sop == exp_q[0][33], "R3 sop", tx_sop, exp_q[0][33]);
        chk(tx_eop == exp_q[0][32], "R3 eop", tx_eop, exp_q[0][32]);
        case (idx)
          0: chk(tx_data == exp_q[0][31:0], "R4/R5/R6 word0", tx_data, exp_q[0][31:0]);
          1: chk(tx_data == exp_q[0][31:0], "R7/R9 word1", tx_data, exp_q[0][31:0]);
          2: chk(tx_data == exp_q[0][31:0], "R8 word2", tx_data, exp_q[0][31:0]);
          default: chk(tx_data == exp_q[0][31:0], "R10 word3", tx_data, exp_q[0][31:0]);
        endcase
      end
      if (!pending && req_valid) begin
        for (int i = 0; i < 4; i++)
          exp_q.push_back({(i == 0), (i == 3), mk_word(i)});
      end else if (pending && tx_ready) begin
        void'(exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    #2;
    case (ready_mode)
      0: tx_ready = 1'b1;
      1: tx_ready = 1'($urandom % 2);
      default: tx_ready = 1'b0;
    endcase
  end

  task automatic send(input bit wr, input int bus, input int dev, input int fn,
                      input int off, input int sz, input logic [31:0] wd);
    @(posedge clk); #2;
    req_write = wr; req_bus = 8'(bus); req_dev = 5'(dev); req_fn = 3'(fn);
    req_offset = 12'(off); req_size = 2'(sz); req_wdata = wd; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (busy || exp_q.size() != 0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 0; req_write = 0; req_bus = 0; req_dev = 0; req_fn = 0;
    req_offset = 0; req_size = 0; req_wdata = 0; sec_bus = 8'd1; root_bus = 8'd0;
    tx_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tx_valid == 0, "R1 tx_valid in reset", tx_valid, 0);
    chk(busy == 0, "R1 busy in reset", busy, 0);
    chk(req_ready == 1, "R1 req_ready in reset", req_ready, 1);
    @(posedge clk); #2;
    rst = 1'b0;
    @(negedge clk);
    chk(tx_valid == 0 && busy == 0 && req_ready == 1, "R1 after reset", {tx_valid, busy, req_ready}, 3'b001);
    run_model = 1;

    // R5: bus equal to secondary -> local; bus above -> forwarded; bus below -> local
    send(0, 1, 0, 0, 12'h000, 2, 32'h0);        drain();
    send(0, 2, 3, 1, 12'h010, 2, 32'h0);        drain();
    sec_bus = 8'd5; root_bus = 8'd4;
    send(1, 3, 7, 2, 12'h020, 2, 32'hCAFE_F00D); drain();

    // R9/R10: byte access on every lane
    for (int l = 0; l < 4; l++) begin
      send(1, 6, 1, 0, 12'h040 + l, 0, 32'hFFFF_FFA5); drain();
    end

    // R9/R10: halfword at lanes 2 and 3 (upper bits drop off), random sink
    ready_mode = 1;
    send(1, 9, 2, 5, 12'h102, 1, 32'h1234_BEEF); drain();
    send(1, 9, 2, 5, 12'h103, 1, 32'h1234_BEEF); drain();
    send(1, 5, 0, 0, 12'h0A1, 1, 32'h0000_5AC3); drain();

    // R8/R10: dword at an unaligned offset, extreme fields
    sec_bus = 8'd254; root_bus = 8'd255;
    send(1, 255, 31, 7, 12'hFFF, 2, 32'h8765_4321); drain();
    send(0, 254, 31, 7, 12'hFFD, 3, 32'h0);          drain();

    // R10: read with non-zero write data still sends zero data
    send(0, 255, 4, 4, 12'h085, 0, 32'hDEAD_BEEF); drain();

    // R11 and R3 stall: hold request and change bus numbers while busy
    ready_mode = 0;
    sec_bus = 8'd10; root_bus = 8'd2;
    send(1, 11, 9, 3, 12'h0C6, 1, 32'h0000_ABCD);
    ready_mode = 2;
    req_valid = 1'b1; req_bus = 8'd200; req_write = 1'b0; req_size = 2'd0;
    req_offset = 12'h333; sec_bus = 8'd0; root_bus = 8'd77;
    repeat (6) @(posedge clk);
    #2 req_valid = 1'b0;
    ready_mode = 1;
    drain();
    sec_bus = 8'd10; root_bus = 8'd2;

    // back-to-back requests with random sink
    for (int k = 0; k < 20; k++) begin
      send(k % 2, k * 13 % 256, k % 32, k % 8, k * 37 % 4096, k % 4, 32'h1357_9BDF ^ (k * 32'h0101_0101));
    end
    drain();

    repeat (3) @(negedge clk);
    chk(!tx_valid && !busy && req_ready, "R2 idle at end", {tx_valid, busy, req_ready}, 3'b001);
    finish_run();
  end
endmodule